// File: doc/BRIEF.md
# Weighted Mapper-Table Transmit Queue Scheduler

This block decides which of sixteen transmit queues may hand its next descriptor to the fetch engine. The order and the weighting come from a table of sixteen programmable entries. Each entry names one queue and a credit, the number of descriptors to take from that queue before the walk moves on. The walk starts at entry 0 when the block is enabled and steps through the entries in a fixed circular order. Listing a queue in several entries, or giving it a larger credit, gives it a larger share of the link.

The grant is combinational from the walk state and the queue status inputs. A queue gets a grant only when it is active, its head descriptor is ready and that head is not flow-controlled. If the current entry does not qualify, the walk moves to the next entry on the following clock and never waits. A flow-controlled head therefore blocks its whole queue, and no fetch is requested for that queue. The consumer pulses `desc_done_i` for each descriptor it takes under a grant. Each pulse uses one credit of the current entry. The table can be written only while the block is disabled.

Top module: `wrr_mapper_sched`

## Requirements
- R1: After reset, entry n holds queue n with a credit of 1. When every queue is eligible and `desc_done_i` is high on every cycle, the grants run through queues 0, 1, ..., 15 and then wrap to 0.
- R2: While `enable_i` is low, `grant_valid_o` is 0 and the walk is held at entry 0. The first cycle after enabling evaluates entry 0.
- R3: An entry with credit c keeps the grant on its queue for up to c accepted descriptors (`desc_done_i` high while granted). The walk then moves to the next entry.
- R4: Several entries may name the same queue. Each such entry grants that queue again, in its own turn in the walk.
- R5: If the current entry's queue is inactive (`q_active_i[q]`=0), there is no grant in that cycle and the next cycle evaluates the next entry.
- R6: If the current entry's queue has a flow-controlled head (`q_fc_i[q]`=1), there is no grant for it and the walk moves to the next entry on the next cycle, even when credit remains.
- R7: If the current entry's queue has no ready head (`q_ready_i[q]`=0), the walk moves to the next entry on the next cycle, even when credit remains.
- R8: An entry with credit 0 never grants and costs exactly one cycle of the walk.
- R9: A write (`map_we_i`=1) changes entry `map_addr_i` to queue `map_qid_i` with credit `map_cnt_i` only when `enable_i` is 0. A write made while enabled is ignored.
- R10: `desc_done_i` has no effect on the walk in a cycle with no grant.
- R11: When every queue is inactive, `grant_valid_o` stays 0.
- R12: While `grant_valid_o` is 1, `grant_qid_o` equals the queue named by the current entry. Entries step as 0, 1, ..., 15, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Scheduler enable; the table is writable only while this is low |
| q_active_i | input | 16 | Per-queue active flag |
| q_ready_i | input | 16 | Per-queue head descriptor present |
| q_fc_i | input | 16 | Per-queue head flow-controlled |
| map_we_i | input | 1 | Table entry write strobe |
| map_addr_i | input | 4 | Table entry index to write |
| map_qid_i | input | 4 | Queue number for the written entry |
| map_cnt_i | input | 4 | Credit for the written entry |
| desc_done_i | input | 1 | One descriptor taken under the current grant |
| grant_valid_o | output | 1 | A queue is granted this cycle |
| grant_qid_o | output | 4 | Granted queue number |

## Verification
Two events can fall in the same cycle: the last credit of an entry is used, and the next entry's queue stops qualifying because it turns inactive, empty or flow-controlled. The walk must then do two things in turn, first step past the used-up entry and then skip the failing one. The bench provokes this with long runs where `desc_done_i` is held high while the active, ready and flow-control flags change at random, over tables that repeat queues and include zero credits. A behavioural model of the table and the walk judges `grant_valid_o` and `grant_qid_o` on every cycle. The bench also writes the table while the block is enabled, then later disables and re-enables it, to show that those writes were dropped.

// File: rtl/wrr_sched_pkg.sv
package wrr_sched_pkg;
  localparam int unsigned DefNumQ   = 16;
  localparam int unsigned DefNumEnt = 16;
  localparam int unsigned DefCntW   = 4;

  typedef enum logic [1:0] {
    WALK_HOME = 2'd0,  // disabled: park at entry 0
    WALK_HOLD = 2'd1,  // stay on entry
    WALK_TAKE = 2'd2,  // consume one credit, stay
    WALK_NEXT = 2'd3   // move to next entry
  } walk_act_e;
endpackage

// File: rtl/wrr_map_table.sv
module wrr_map_table #(
  parameter int unsigned NUM_Q   = 16,
  parameter int unsigned NUM_ENT = 16,
  parameter int unsigned CNT_W   = 4,
  localparam int unsigned QID_W  = $clog2(NUM_Q),
  localparam int unsigned ENT_W  = $clog2(NUM_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             we_i,
  input  logic [ENT_W-1:0] waddr_i,
  input  logic [QID_W-1:0] wqid_i,
  input  logic [CNT_W-1:0] wcnt_i,
  input  logic [ENT_W-1:0] ridx_i,
  output logic [QID_W-1:0] rqid_o,
  output logic [CNT_W-1:0] rcnt_o
);
  logic [NUM_ENT-1:0][QID_W-1:0] qid_q;
  logic [NUM_ENT-1:0][CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic hit;
    assign hit = we_i && !lock_i && (waddr_i == ENT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        qid_q[g] <= QID_W'(g % NUM_Q);
        cnt_q[g] <= CNT_W'(1);
      end else if (hit) begin
        qid_q[g] <= wqid_i;
        cnt_q[g] <= wcnt_i;
      end
    end
  end

  assign rqid_o = qid_q[ridx_i];
  assign rcnt_o = cnt_q[ridx_i];

  // R9: table frozen while the scheduler runs
  p_table_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_i) |-> ($stable(qid_q) && $stable(cnt_q)));
endmodule

// File: rtl/wrr_head_check.sv
module wrr_head_check #(
  parameter int unsigned NUM_Q  = 16,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned QID_W = $clog2(NUM_Q)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [NUM_Q-1:0] active_i,
  input  logic [NUM_Q-1:0] ready_i,
  input  logic [NUM_Q-1:0] fc_i,
  input  logic [QID_W-1:0] qid_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             elig_o,
  output logic             grant_o
);
  logic q_ok;
  logic credit_left;

  assign q_ok        = active_i[qid_i] && ready_i[qid_i] && !fc_i[qid_i];
  assign credit_left = used_i < cnt_i;
  assign elig_o      = q_ok && credit_left;
  assign grant_o     = enable_i && elig_o;

  // R6: never request a fetch from a blocked head
  p_no_fc_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !fc_i[qid_i]);
  // R5, R7: only an active queue with a ready head
  p_grant_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (active_i[qid_i] && ready_i[qid_i]));
  // R11
  p_idle_no_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i == '0) |-> !grant_o);
endmodule

// File: rtl/wrr_walker.sv
module wrr_walker
  import wrr_sched_pkg::*;
#(
  parameter int unsigned NUM_ENT = 16,
  parameter int unsigned CNT_W   = 4,
  localparam int unsigned ENT_W  = $clog2(NUM_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             elig_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [ENT_W-1:0] ptr_o,
  output logic [CNT_W-1:0] used_o
);
  logic [ENT_W-1:0] ptr_q;
  logic [CNT_W-1:0] used_q;
  walk_act_e        act;
  logic             last;

  assign last = (used_q + CNT_W'(1)) == cnt_i;

  always_comb begin
    if (!enable_i)            act = WALK_HOME;
    else if (!elig_i)         act = WALK_NEXT;
    else if (!done_i)         act = WALK_HOLD;
    else if (last)            act = WALK_NEXT;
    else                      act = WALK_TAKE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      used_q <= '0;
    end else begin
      unique case (act)
        WALK_HOME: begin ptr_q <= '0; used_q <= '0; end
        WALK_NEXT: begin
          ptr_q  <= (ptr_q == ENT_W'(NUM_ENT - 1)) ? '0 : ptr_q + ENT_W'(1);
          used_q <= '0;
        end
        WALK_TAKE: used_q <= used_q + CNT_W'(1);
        default:   ;
      endcase
    end
  end

  assign ptr_o  = ptr_q;
  assign used_o = used_q;

  // R3: credits consumed never exceed the entry's credit
  p_credit_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q == '0) || (used_q < cnt_i));
  // R2: parked at entry 0 after a disabled cycle
  p_home_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (ptr_q == '0 && used_q == '0));
  // R10: stray done leaves credit untouched
  p_stray_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !elig_i) |=> (used_q == '0));
endmodule

// File: rtl/wrr_mapper_sched.sv
module wrr_mapper_sched
  import wrr_sched_pkg::*;
#(
  parameter int unsigned NUM_Q   = DefNumQ,
  parameter int unsigned NUM_ENT = DefNumEnt,
  parameter int unsigned CNT_W   = DefCntW,
  localparam int unsigned QID_W  = $clog2(NUM_Q),
  localparam int unsigned ENT_W  = $clog2(NUM_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [NUM_Q-1:0] q_active_i,
  input  logic [NUM_Q-1:0] q_ready_i,
  input  logic [NUM_Q-1:0] q_fc_i,
  input  logic             map_we_i,
  input  logic [ENT_W-1:0] map_addr_i,
  input  logic [QID_W-1:0] map_qid_i,
  input  logic [CNT_W-1:0] map_cnt_i,
  input  logic             desc_done_i,
  output logic             grant_valid_o,
  output logic [QID_W-1:0] grant_qid_o
);
  logic [ENT_W-1:0] ptr;
  logic [CNT_W-1:0] used;
  logic [QID_W-1:0] cur_qid;
  logic [CNT_W-1:0] cur_cnt;
  logic             elig;
  logic             grant;

  wrr_map_table #(.NUM_Q(NUM_Q), .NUM_ENT(NUM_ENT), .CNT_W(CNT_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (enable_i),
    .we_i    (map_we_i),
    .waddr_i (map_addr_i),
    .wqid_i  (map_qid_i),
    .wcnt_i  (map_cnt_i),
    .ridx_i  (ptr),
    .rqid_o  (cur_qid),
    .rcnt_o  (cur_cnt)
  );

  wrr_head_check #(.NUM_Q(NUM_Q), .CNT_W(CNT_W)) u_check (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .active_i (q_active_i),
    .ready_i  (q_ready_i),
    .fc_i     (q_fc_i),
    .qid_i    (cur_qid),
    .used_i   (used),
    .cnt_i    (cur_cnt),
    .elig_o   (elig),
    .grant_o  (grant)
  );

  wrr_walker #(.NUM_ENT(NUM_ENT), .CNT_W(CNT_W)) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .elig_i   (elig),
    .done_i   (desc_done_i),
    .cnt_i    (cur_cnt),
    .ptr_o    (ptr),
    .used_o   (used)
  );

  assign grant_valid_o = grant;
  assign grant_qid_o   = cur_qid;

  // R2: nothing granted while disabled
  p_off_no_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !grant_valid_o);
  // R8: a zero-credit entry never grants
  p_zero_credit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_cnt == '0) |-> !grant_valid_o);
endmodule

// File: tb/sim_wrr_mapper_sched.sv
module sim_wrr_mapper_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, done = 1'b0, we = 1'b0;
  logic [15:0] act = '0, rdy = '0, fc = '0;
  logic [3:0]  waddr = '0, wq = '0, wc = '0;
  logic        gv;
  logic [3:0]  gq;

  int n_run = 0, n_fail = 0;
  int m_q[16], m_c[16];
  int ptr = 0, used = 0;

  always #4 clk = ~clk;

  wrr_mapper_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .q_active_i(act), .q_ready_i(rdy), .q_fc_i(fc),
    .map_we_i(we), .map_addr_i(waddr), .map_qid_i(wq), .map_cnt_i(wc),
    .desc_done_i(done), .grant_valid_o(gv), .grant_qid_o(gq)
  );

  task automatic model_update();
    int q;
    bit el;
    if (!en) begin
      ptr = 0; used = 0;
      if (we) begin m_q[waddr] = int'(wq); m_c[waddr] = int'(wc); end
    end else begin
      q  = m_q[ptr];
      el = act[q] && rdy[q] && !fc[q] && (used < m_c[ptr]);
      if (!el) begin ptr = (ptr + 1) % 16; used = 0; end
      else if (done) begin
        if (used + 1 == m_c[ptr]) begin ptr = (ptr + 1) % 16; used = 0; end
        else used++;
      end
    end
  endtask

  // called at a negedge with inputs already set
  task automatic step(input string tag);
    int  q;
    bit  exp_v;
    #1;
    q = m_q[ptr];
    exp_v = en && act[q] && rdy[q] && !fc[q] && (used < m_c[ptr]);
    n_run++;
    if (gv !== exp_v) begin
      n_fail++;
      $display("FAIL %s grant_valid act=%0b exp=%0b (entry %0d)", tag, gv, exp_v, ptr);
    end
    if (exp_v) begin
      n_run++;
      if (gq !== 4'(q)) begin
        n_fail++;
        $display("FAIL %s grant_qid act=%0d exp=%0d", tag, gq, q);
      end
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic run(input string tag, input int n, input int p_done);
    for (int i = 0; i < n; i++) begin
      done = (($urandom % 100) < p_done);
      step(tag);
    end
  endtask

  task automatic wr(input int a, input int q, input int c);
    we = 1'b1; waddr = 4'(a); wq = 4'(q); wc = 4'(c);
    step("R9");
    we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_q[i] = i; m_c[i] = 1; end
    @(negedge clk);
    repeat (3) begin
      n_run++;
      if (gv !== 1'b0) begin n_fail++; $display("FAIL R2 reset grant act=%0b exp=0", gv); end
      @(negedge clk);
    end
    rst_n = 1'b1;
    act = '1; rdy = '1; fc = '0;

    // R1 default equal weighting, queues 0..15 then wrap
    en = 1'b1;
    run("R1", 20, 100);
    // R2 restart at entry 0
    en = 1'b0; run("R2", 2, 100);
    en = 1'b1; run("R2", 5, 100);
    // R10 stray done while disabled / no grant
    en = 1'b0; run("R10", 2, 100);

    // program repeats and zero credit
    wr(0, 3, 3); wr(1, 5, 2); wr(2, 3, 1); wr(3, 7, 0); wr(4, 3, 4);
    en = 1'b1;
    run("R3", 14, 100);
    run("R4", 30, 60);
    run("R8", 20, 100);
    // R9 writes while enabled are dropped
    we = 1'b1; waddr = 4'd0; wq = 4'd9; wc = 4'd5;
    run("R9", 6, 50);
    we = 1'b0;
    en = 1'b0; run("R9", 1, 0);
    en = 1'b1; run("R9", 12, 100);

    // R5 inactive queues skipped
    act = 16'hFF57; run("R5", 30, 100);
    act = '1;
    // R6 flow-controlled head stalls its queue
    fc = 16'h0008; run("R6", 30, 100);
    fc = '0;
    // R7 empty head moves on
    rdy = 16'hFFDF; run("R7", 30, 80);
    rdy = '1;
    // R10 done held with an inactive queue in the walk
    act = 16'hFFDF; done = 1'b1;
    for (int i = 0; i < 20; i++) step("R10");
    act = '1;
    // R11 all inactive
    act = '0; run("R11", 40, 100);
    act = '1;

    // R12 random mix, collisions of last credit and failing next entry
    for (int blk = 0; blk < 30; blk++) begin
      en = 1'b0;
      for (int k = 0; k < 4; k++)
        wr($urandom % 16, $urandom % 16, $urandom % 5);
      en = 1'b1;
      for (int i = 0; i < 200; i++) begin
        act  = 16'($urandom) | 16'($urandom);
        rdy  = 16'($urandom) | 16'($urandom);
        fc   = 16'($urandom) & 16'($urandom) & 16'($urandom);
        done = ($urandom % 4) != 0;
        we   = ($urandom % 8) == 0;
        waddr = 4'($urandom); wq = 4'($urandom); wc = 4'($urandom);
        step("R12");
      end
      we = 1'b0;
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule